// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes left/right sample pairs from a valid/ready stream and shifts them out, most significant bit first, on a three-wire serial audio link made of a bit clock, a word select and a data line. With the master select high it makes the bit clock and word select itself from the system clock. With the master select low it follows a bit clock and word select supplied from outside. A format input chooses between I2S framing, where the first data bit comes one bit clock after the word-select edge, and MSB-justified framing, where the first data bit comes right at that edge.

A sample pair is taken from the stream into a one-entry holding register. It moves into the shifter when the next left half-frame starts. If no new pair has arrived by then, the pair already in the shifter is sent again. Back-pressure works as follows. `s_ready` is high while the holding register is empty. A transfer happens on a clock edge where `s_valid` and `s_ready` are both high. After a transfer, `s_ready` stays low until that pair has moved into the shifter. While `s_valid` is high and `s_ready` is low, the source keeps its data stable.

While power-down is high, or after reset, the data line is held low. After power-down is released, it stays low for a set number of frames before data goes out.

Top module: `audio_serial_tx`

## Requirements
- R1: With `master_sel` high, `bck_out` has a period of SYSCLK_DIV clocks with a 50% duty cycle. `ws_out` has a period of 2·SLOT_W bit clocks and changes only on the clock where `bck_out` falls. `bck_oe` and `ws_oe` are high.
- R2: With `master_sel` low, `bck_oe` and `ws_oe` are low, and framing follows `bck_in` and `ws_in`.
- R3: `sdata` changes only together with a falling bit-clock edge. The one exception is being forced low by power-down.
- R4: Word select low carries the left sample and high carries the right sample. Each sample is sent MSB first, SAMPLE_W bits in all. With `fmt_sel` = 1 (MSB-justified), the MSB is bit slot 0 of the half-frame. With `fmt_sel` = 0 (I2S), the MSB is bit slot 1.
- R5: Every slot of a half-frame outside the SAMPLE_W data slots is sent as 0. This includes slot 0 in I2S framing and every slot after the LSB.
- R6: `s_ready` is high exactly while the holding register is empty. After a transfer, it stays low until the next left half-frame starts.
- R7: A pair is sent from the left half-frame that follows its transfer. When no new pair has arrived, the previous pair is repeated. Before any transfer, the pair is all zeros.
- R8: Count left half-frame starts after reset or after power-down is released. Frames 1 to MUTE_FRAMES are all zero. Data first appears in frame MUTE_FRAMES+1.
- R9: While `pwr_down` is high, `sdata` is 0 from the next clock onward, and the mute count starts again.
- R10: In slave mode, data bits are sent in the same framing, taken from the synchronised falling edges of `bck_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 1 = generate bit clock and word select, 0 = follow them |
| fmt_sel | input | 1 | 0 = I2S framing, 1 = MSB-justified framing |
| pwr_down | input | 1 | Holds data low and restarts the mute count |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| bck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| bck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| bck_oe | output | 1 | Drive enable for bit clock |
| ws_oe | output | 1 | Drive enable for word select |
| sdata | output | 1 | Serial data |

## Verification
The bench builds the block with SAMPLE_W 24, SLOT_W 32 and SYSCLK_DIV 4. MUTE_FRAMES is 2, so that leaving the mute and the all-zero frames before it can both be seen within a few frames. That value is far below the deployed count. The slave bit clock runs at a sixteenth of the system clock, which leaves room for the synchroniser delay before each rising edge. With these values, both framings, both clocking modes, stalls of the holding register and a power-down in the middle of a frame are all covered in a short run.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_MSBJ = 1'b1
  } frame_fmt_e;
endpackage

// File: rtl/atx_clkgen.sv
module atx_clkgen #(
  parameter int DIV    = 4,
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic bck,
  output logic ws,
  output logic tick,
  output logic ws_next
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(2 * SLOT_W);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [BW-1:0] bit_q, bit_nx;
  logic          bck_q, ws_q;

  always_comb begin
    tick    = (cnt_q == CW'(DIV - 1));
    cnt_nx  = tick ? '0 : cnt_q + CW'(1);
    bit_nx  = bit_q + BW'(1);
    ws_next = bit_nx[BW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= '1;
      bck_q <= 1'b0;
      ws_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      bck_q <= (cnt_nx >= CW'(DIV / 2));
      if (tick) begin
        bit_q <= bit_nx;
        ws_q  <= bit_nx[BW-1];
      end
    end
  end

  assign bck = bck_q;
  assign ws  = ws_q;

  // R1
  ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> $fell(bck_q));
endmodule

// File: rtl/atx_slave_sync.sv
module atx_slave_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic ws_in,
  output logic tick,
  output logic ws_now
);
  logic [2:0] bck_sr;
  logic [1:0] ws_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_sr <= '0;
      ws_sr  <= '1;
    end else begin
      bck_sr <= {bck_sr[1:0], bck_in};
      ws_sr  <= {ws_sr[0], ws_in};
    end
  end

  assign tick   = bck_sr[2] & ~bck_sr[1];
  assign ws_now = ws_sr[1];
endmodule

// File: rtl/atx_mute.sv
module atx_mute #(
  parameter int FRAMES = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic lstart,
  output logic quiet
);
  localparam int CW = $clog2(FRAMES + 1);

  logic [CW-1:0] cnt_q;
  logic          mute_q;
  logic          release_now;

  assign release_now = lstart && (cnt_q == CW'(FRAMES));
  assign quiet       = pwr_down | (mute_q & ~release_now);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      cnt_q  <= '0;
      mute_q <= 1'b1;
    end else if (lstart && mute_q) begin
      if (cnt_q == CW'(FRAMES)) mute_q <= 1'b0;
      else                      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
  import atx_pkg::*;
#(
  parameter int SW     = 24,
  parameter int SLOT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ws_now,
  input  logic          fmt,
  input  logic          quiet,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  output logic          lstart,
  output logic          sdata
);
  localparam int PW = $clog2(SLOT_W) + 1;
  localparam int IW = (SW > 1) ? $clog2(SW) : 1;

  logic [SW-1:0] hold_l, hold_r, cur_l, cur_r, l_nx, r_nx, word;
  logic          pending, ws_q, sdata_q, half_new, load, bit_nx;
  logic [PW-1:0] pos_q, pos_nx;
  int            off, q, sel;

  always_comb begin
    half_new = (ws_now != ws_q);
    pos_nx   = half_new ? '0 : ((pos_q == '1) ? pos_q : pos_q + PW'(1));
    lstart   = tick & half_new & ~ws_now;
    load     = lstart & pending;
    l_nx     = load ? hold_l : cur_l;
    r_nx     = load ? hold_r : cur_r;
    word     = ws_now ? r_nx : l_nx;
    off      = (frame_fmt_e'(fmt) == FMT_MSBJ) ? 0 : 1;
    q        = int'(pos_nx);
    sel      = SW - 1 + off - q;
    bit_nx   = (q >= off && q < off + SW) ? word[sel[IW-1:0]] : 1'b0;
  end

  assign s_ready = ~pending;
  assign sdata   = sdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l  <= '0;
      hold_r  <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
      pending <= 1'b0;
      ws_q    <= 1'b1;
      pos_q   <= '0;
      sdata_q <= 1'b0;
    end else begin
      if (s_valid && !pending) begin
        hold_l  <= s_left;
        hold_r  <= s_right;
        pending <= 1'b1;
      end else if (load) begin
        pending <= 1'b0;
      end
      if (tick) begin
        ws_q  <= ws_now;
        pos_q <= pos_nx;
        cur_l <= l_nx;
        cur_r <= r_nx;
      end
      if (quiet)     sdata_q <= 1'b0;
      else if (tick) sdata_q <= bit_nx;
    end
  end

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l != $past(cur_l) || cur_r != $past(cur_r)) |-> $past(lstart));
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int SYSCLK_DIV  = 4,
  parameter int MUTE_FRAMES = 12288
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master_sel,
  input  logic                fmt_sel,
  input  logic                pwr_down,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                bck_in,
  input  logic                ws_in,
  output logic                bck_out,
  output logic                ws_out,
  output logic                bck_oe,
  output logic                ws_oe,
  output logic                sdata
);
  logic m_tick, m_wsn, s_tick, s_wsn, tick, ws_now, lstart, quiet;

  atx_clkgen #(.DIV(SYSCLK_DIV), .SLOT_W(SLOT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .bck(bck_out), .ws(ws_out),
    .tick(m_tick), .ws_next(m_wsn));

  atx_slave_sync u_sync (
    .clk(clk), .rst_n(rst_n), .bck_in(bck_in), .ws_in(ws_in),
    .tick(s_tick), .ws_now(s_wsn));

  assign tick   = master_sel ? m_tick : s_tick;
  assign ws_now = master_sel ? m_wsn  : s_wsn;
  assign bck_oe = master_sel;
  assign ws_oe  = master_sel;

  atx_mute #(.FRAMES(MUTE_FRAMES)) u_mute (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .lstart(lstart),
    .quiet(quiet));

  atx_shifter #(.SW(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ws_now(ws_now), .fmt(fmt_sel),
    .quiet(quiet), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .lstart(lstart), .sdata(sdata));

  // R3
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && !$past(pwr_down) && sdata != $past(sdata))
      |-> $fell(bck_out));
  // R9
  quiet_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !sdata);
endmodule

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
  localparam int SW = 24, SLOT = 32, DIV = 4, MF = 2, NB = 60;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, master_sel = 1'b1, fmt_sel = 1'b1, pwr_down = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [SW-1:0] s_left = '0, s_right = '0;
  logic bck_in = 1'b0, ws_in = 1'b1;
  logic bck_out, ws_out, bck_oe, ws_oe, sdata;
  logic slv_run = 1'b0;
  logic [9:0] sc = 10'd511;

  int n_chk = 0, n_bad = 0, fidx = 0;
  logic bprev = 1'b0, wprev = 1'b1;
  wire bline = master_sel ? bck_out : bck_in;
  wire wline = master_sel ? ws_out : ws_in;

  audio_serial_tx #(.SAMPLE_W(SW), .SLOT_W(SLOT), .SYSCLK_DIV(DIV),
                    .MUTE_FRAMES(MF)) u_audio_serial_tx (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .fmt_sel(fmt_sel),
    .pwr_down(pwr_down), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .bck_in(bck_in), .ws_in(ws_in),
    .bck_out(bck_out), .ws_out(ws_out), .bck_oe(bck_oe), .ws_oe(ws_oe),
    .sdata(sdata));

  always @(negedge clk) begin
    if (!rst_n || pwr_down) fidx <= 0;
    else if (wprev && !wline) fidx <= fidx + 1;
    wprev <= wline;
    bprev <= bline;
  end

  initial begin : slv_gen
    logic [9:0] nx;
    forever begin
      @(posedge clk);
      if (slv_run) begin
        nx = sc + 10'd1;
        sc <= nx;
        bck_in <= nx[3];
        ws_in <= nx[9];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [SW-1:0] l, r,
                                            input logic msbj);
    logic [63:0] v = '0;
    for (int p = 0; p < NB; p++) begin
      int qq = p % SLOT;
      int o = msbj ? 0 : 1;
      logic [SW-1:0] w = (p >= SLOT) ? r : l;
      if (qq >= o && qq < o + SW) v[p] = w[SW-1-(qq-o)];
    end
    return v;
  endfunction

  function automatic logic [63:0] pad_mask(input logic msbj);
    logic [63:0] m = '0;
    for (int p = 0; p < NB; p++) begin
      int qq = p % SLOT;
      int o = msbj ? 0 : 1;
      if (!(qq >= o && qq < o + SW)) m[p] = 1'b1;
    end
    return m;
  endfunction

  task automatic do_reset(input logic ms, input logic fmt);
    rst_n = 1'b0; master_sel = ms; fmt_sel = fmt; pwr_down = 1'b0;
    s_valid = 1'b0; slv_run = !ms; sc = 10'd511;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic cap(output logic [63:0] bits, output int idx);
    bits = '0; idx = 0;
    do @(negedge clk); while (wline !== 1'b1);
    do @(negedge clk); while (wline !== 1'b0);
    for (int i = 0; i < NB; i++) begin
      do @(negedge clk); while (!(bline === 1'b1 && bprev === 1'b0));
      if (i == 0) idx = fidx;
      bits[i] = sdata;
    end
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b1);
    chk(s_ready === 1'b1, "R6 ready after reset", 64'(s_ready), 64'd1);
    chk(sdata === 1'b0, "R8 sdata after reset", 64'(sdata), 64'd0);
  endtask

  task automatic t_master_clk;
    int n;
    chk(bck_oe === 1'b1 && ws_oe === 1'b1, "R1 drive enables", {bck_oe, ws_oe}, 64'd3);
    do @(negedge clk); while (!(bck_out && !bprev));
    n = 0;
    do begin @(negedge clk); n++; end while (!(bck_out && !bprev));
    chk(n == DIV, "R1 bit clock period", 64'(n), 64'(DIV));
    do @(negedge clk); while (!(!ws_out && wprev));
    n = 0;
    do begin @(negedge clk); n++; end while (!(!ws_out && wprev));
    chk(n == DIV * 2 * SLOT, "R1 word select period", 64'(n), 64'(DIV * 2 * SLOT));
  endtask

  task automatic t_mute_msbj;
    logic [63:0] b; int idx; logic [63:0] e;
    do_reset(1'b1, 1'b1);
    push(24'hA5C3F1, 24'h5E0D17);
    do begin
      cap(b, idx);
      e = (idx <= MF) ? 64'd0 : exp_frame(24'hA5C3F1, 24'h5E0D17, 1'b1);
      chk(b === e, (idx <= MF) ? "R8 muted frame" : "R4 MSB-justified frame", b, e);
    end while (idx <= MF);
    cap(b, idx);
    e = exp_frame(24'hA5C3F1, 24'h5E0D17, 1'b1);
    chk(b === e, "R7 pair repeated", b, e);
  endtask

  task automatic t_i2s;
    logic [63:0] b; int idx; logic [63:0] e;
    fmt_sel = 1'b0;
    push(24'hFFFFFF, 24'h800001);
    cap(b, idx);
    e = exp_frame(24'hFFFFFF, 24'h800001, 1'b0);
    chk(b === e, "R4 I2S frame", b, e);
    chk((b & pad_mask(1'b0)) === 64'd0, "R5 padding zero", b & pad_mask(1'b0), 64'd0);
  endtask

  task automatic t_stream;
    logic [63:0] b; int idx; logic [63:0] e;
    push(24'h123456, 24'hABCDEF);
    chk(s_ready === 1'b0, "R6 ready low while pair waits", 64'(s_ready), 64'd0);
    cap(b, idx);
    e = exp_frame(24'h123456, 24'hABCDEF, 1'b0);
    chk(b === e, "R7 pair from next frame", b, e);
    chk(s_ready === 1'b1, "R6 ready after load", 64'(s_ready), 64'd1);
    fmt_sel = 1'b1;
    push(24'hFFFFFF, 24'hFFFFFF);
    cap(b, idx);
    e = exp_frame(24'hFFFFFF, 24'hFFFFFF, 1'b1);
    chk(b === e, "R7 second pair", b, e);
    chk((b & pad_mask(1'b1)) === 64'd0, "R5 padding zero MSB-justified",
        b & pad_mask(1'b1), 64'd0);
  endtask

  task automatic t_pwr;
    logic [63:0] b; int idx; logic [63:0] e;
    repeat (37) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sdata === 1'b0, "R9 low after power-down", 64'(sdata), 64'd0);
    cap(b, idx);
    chk(b === 64'd0, "R9 frame during power-down", b, 64'd0);
    pwr_down = 1'b0;
    do begin
      cap(b, idx);
      e = (idx <= MF) ? 64'd0 : exp_frame(24'hFFFFFF, 24'hFFFFFF, 1'b1);
      chk(b === e, (idx <= MF) ? "R8 muted after power-down" : "R8 data after mute", b, e);
    end while (idx <= MF);
  endtask

  task automatic t_slave;
    logic [63:0] b; int idx; logic [63:0] e;
    do_reset(1'b0, 1'b1);
    chk(bck_oe === 1'b0 && ws_oe === 1'b0, "R2 slave not driving", {bck_oe, ws_oe}, 64'd0);
    push(24'h0F0F0F, 24'hC0FFEE);
    do begin
      cap(b, idx);
      e = (idx <= MF) ? 64'd0 : exp_frame(24'h0F0F0F, 24'hC0FFEE, 1'b1);
      chk(b === e, (idx <= MF) ? "R8 slave muted" : "R10 slave MSB-justified", b, e);
    end while (idx <= MF);
    fmt_sel = 1'b0;
    push(24'h7FFFFE, 24'h000001);
    cap(b, idx);
    e = exp_frame(24'h7FFFFE, 24'h000001, 1'b0);
    chk(b === e, "R10 slave I2S", b, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master_clk();
    t_mute_msbj();
    t_i2s();
    t_stream();
    t_pwr();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule